// File: doc/BRIEF.md
# Threshold Window Interrupt with Persistence

This block screens each new light-conversion result against a programmable 16-bit window given by a lower and an upper bound. A result at or below the lower bound, or at or above the upper bound, counts as out of window. The block keeps a run of consecutive out-of-window results. When that run reaches the length chosen by a 2-bit persistence field, a latched interrupt is raised.

The interrupt shows up on two outputs. One is a drive-low enable for an active-low, open-drain pin. The other is an active-high status bit. Both stay set until the register interface pulses the clear input, which it does when a bus read of the control register completes. Results keep arriving and keep being evaluated while the interrupt is pending. After reset the register file supplies a lower bound of 0x0000 and an upper bound of 0xFFFF, so only the two extreme codes trip the window. Register storage and bus handling sit outside this block.

Top module: `light_window_irq`

## Requirements
- R1: A result strobed with `res_vld_i` high is out of window when `res_i <= thr_lo_i` or `res_i >= thr_hi_i`; values strictly between the bounds are in window.
- R2: `persist_i` selects the run length N: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 16 consecutive out-of-window results. The interrupt sets on the Nth one and not earlier.
- R3: Any strobed in-window result restarts the consecutive run from zero.
- R4: The run saturates at N. While an unbroken out-of-window run continues, every further out-of-window result sets the interrupt again, including right after a clear.
- R5: `irq_pull_o` (1 = pull the pin low) and `irq_stat_o` (1 = pending) go high together in the cycle after the strobe that completes the run. They then hold while no clear arrives, whatever results are strobed in the meantime.
- R6: A one-cycle `clr_i` pulse drops both outputs in the following cycle when no set occurs in the same cycle.
- R7: When `clr_i` and a run-completing strobe occur in the same cycle, the interrupt stays asserted.
- R8: Any change of `persist_i` restarts the consecutive run from zero.
- R9: Cycles with `res_vld_i` low neither count toward the run nor break it, whatever value `res_i` holds.
- R10: After reset both outputs are low.
- R11: With bounds 0x0000 and 0xFFFF and N = 1, only results 0x0000 and 0xFFFF set the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | 16 | Conversion result |
| res_vld_i | input | 1 | Result strobe, one cycle per new result |
| thr_lo_i | input | 16 | Lower window bound (inclusive) |
| thr_hi_i | input | 16 | Upper window bound (inclusive) |
| persist_i | input | 2 | Run-length select |
| clr_i | input | 1 | Interrupt clear pulse |
| irq_pull_o | output | 1 | Drive-low enable for the active-low interrupt pin |
| irq_stat_o | output | 1 | Interrupt status, active high |

## Verification
The bench drives results that sit exactly on each bound and one code inside them. A design with exclusive bounds would miss the set on the bound, and an off-by-one run counter would fire one result early or late for some N. It breaks runs with an in-window result and with a persistence change just before the run would complete. A counter that is not restarted would fire too soon. It also clears the interrupt while a saturated run continues, and issues a clear in the same cycle as a set. A counter that wraps, or a latch that lets clear win, would leave the status low where it must be high.

// File: rtl/lwi_pkg.sv
package lwi_pkg;
  typedef enum logic [1:0] {
    PERS_1  = 2'b00,
    PERS_4  = 2'b01,
    PERS_8  = 2'b10,
    PERS_16 = 2'b11
  } persist_e;

  localparam int unsigned MAX_RUN = 16;
  localparam int unsigned CNT_W   = $clog2(MAX_RUN + 1);

  function automatic logic [CNT_W-1:0] run_len(persist_e p);
    case (p)
      PERS_1:  return CNT_W'(1);
      PERS_4:  return CNT_W'(4);
      PERS_8:  return CNT_W'(8);
      default: return CNT_W'(MAX_RUN);
    endcase
  endfunction
endpackage

// File: rtl/lwi_window_cmp.sv
module lwi_window_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output logic              out_o
);
  logic below, above;
  // inclusive bounds on both sides
  assign below = (res_i <= lo_i);
  assign above = (res_i >= hi_i);
  assign out_o = below | above;
endmodule

// File: rtl/lwi_run_ctr.sv
module lwi_run_ctr
  import lwi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     vld_i,
  input  logic     out_i,
  input  persist_e persist_i,
  output logic     hit_o
);
  persist_e         persist_q;
  logic             pers_chg;
  logic [CNT_W-1:0] cnt_q, cnt_d, base, inc, need;

  assign pers_chg = (persist_i != persist_q);
  assign need     = run_len(persist_i);
  assign base     = pers_chg ? '0 : cnt_q;
  assign inc      = base + CNT_W'(1);
  assign hit_o    = vld_i && out_i && (inc >= need);

  always_comb begin
    cnt_d = base;
    if (vld_i) begin
      if (!out_i)     cnt_d = '0;
      else if (hit_o) cnt_d = need;   // saturate at N
      else            cnt_d = inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      persist_q <= PERS_1;
    end else begin
      cnt_q     <= cnt_d;
      persist_q <= persist_i;
    end
  end

  p_inwin_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !out_i) |=> (cnt_q == '0));

  p_chg_restarts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pers_chg && !vld_i) |=> (cnt_q == '0));

  p_run_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && out_i && !pers_chg && !hit_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_RUN));

  p_idle_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !pers_chg) |=> $stable(cnt_q));
endmodule

// File: rtl/lwi_irq_latch.sv
module lwi_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic stat_o
);
  logic stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= 1'b0;
    else if (set_i)  stat_q <= 1'b1;   // set beats clear
    else if (clr_i)  stat_q <= 1'b0;
  end

  assign stat_o = stat_q;

  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> stat_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && !clr_i) |=> stat_o);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !stat_o);

  p_rise_needs_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o) |-> $past(set_i));
endmodule

// File: rtl/light_window_irq.sv
module light_window_irq
  import lwi_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] res_i,
  input  logic              res_vld_i,
  input  logic [DATA_W-1:0] thr_lo_i,
  input  logic [DATA_W-1:0] thr_hi_i,
  input  logic [1:0]        persist_i,
  input  logic              clr_i,
  output logic              irq_pull_o,
  output logic              irq_stat_o
);
  logic out_win, hit, stat;

  lwi_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .res_i (res_i),
    .lo_i  (thr_lo_i),
    .hi_i  (thr_hi_i),
    .out_o (out_win)
  );

  lwi_run_ctr u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (res_vld_i),
    .out_i     (out_win),
    .persist_i (persist_e'(persist_i)),
    .hit_o     (hit)
  );

  lwi_irq_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr_i),
    .stat_o (stat)
  );

  assign irq_stat_o = stat;
  assign irq_pull_o = stat;

  p_hit_needs_oow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (res_vld_i && ((res_i <= thr_lo_i) || (res_i >= thr_hi_i))));

  p_pin_matches_stat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pull_o == irq_stat_o);
endmodule

// File: tb/tb_light_window_irq.sv
module tb_light_window_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] res = '0;
  logic        vld = 1'b0;
  logic [15:0] lo = '0;
  logic [15:0] hi = '0;
  logic [1:0]  pers = 2'b00;
  logic        clr = 1'b0;
  logic        pull, stat;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  light_window_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .res_i(res), .res_vld_i(vld),
    .thr_lo_i(lo), .thr_hi_i(hi), .persist_i(pers), .clr_i(clr),
    .irq_pull_o(pull), .irq_stat_o(stat)
  );

  // behavioural reference
  int m_run, m_prev;
  bit m_irq;

  function automatic int need_of(logic [1:0] p);
    case (p)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_prev = 0; m_irq = 0;
    end else begin
      int b;
      bit h;
      h = 0;
      b = (int'(pers) != m_prev) ? 0 : m_run;
      m_prev = int'(pers);
      if (vld) begin
        if (res <= lo || res >= hi) begin
          b = b + 1;
          if (b >= need_of(pers)) begin b = need_of(pers); h = 1; end
        end else b = 0;
      end
      m_run = b;
      if (h) m_irq = 1;
      else if (clr) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (stat !== m_irq || pull !== m_irq) begin
        bad++;
        $display("FAIL %s model: stat=%0b pull=%0b exp=%0b", cur_req, stat, pull, m_irq);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog: cycles=%0d exp<=20000", cyc);
      $display("test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  task automatic chk(bit exp, string req);
    checks++;
    if (stat !== exp || pull !== exp) begin
      bad++;
      $display("FAIL %s: stat=%0b pull=%0b exp=%0b", req, stat, pull, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic pulse(logic [15:0] v);
    res = v; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic pulse_n(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) pulse(v);
  endtask

  task automatic do_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic set_pers(logic [1:0] p);
    pers = p;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R10"; chk(1'b0, "R10 reset");

    lo = 16'd100; hi = 16'd200;
    cur_req = "R1";
    pulse(16'd150); chk(1'b0, "R1 mid");
    pulse(16'd100); chk(1'b1, "R1 lower bound");
    cur_req = "R6";
    do_clr();       chk(1'b0, "R6 clear");
    cur_req = "R1";
    pulse(16'd200); chk(1'b1, "R1 upper bound");
    do_clr();
    pulse(16'd101); chk(1'b0, "R1 lo+1");
    pulse(16'd199); chk(1'b0, "R1 hi-1");

    cur_req = "R2";
    set_pers(2'b01);
    pulse_n(16'd5, 3);   chk(1'b0, "R2 N4 at 3");
    pulse(16'd5);        chk(1'b1, "R2 N4 at 4");
    do_clr();
    set_pers(2'b10);
    pulse_n(16'd250, 7); chk(1'b0, "R2 N8 at 7");
    pulse(16'd250);      chk(1'b1, "R2 N8 at 8");
    do_clr();
    set_pers(2'b11);
    pulse_n(16'd0, 15);  chk(1'b0, "R2 N16 at 15");
    pulse(16'd0);        chk(1'b1, "R2 N16 at 16");
    do_clr();

    cur_req = "R3";
    set_pers(2'b01);
    pulse_n(16'd5, 3); pulse(16'd150); pulse_n(16'd5, 3);
    chk(1'b0, "R3 broken run");
    pulse(16'd5);      chk(1'b1, "R3 rebuilt run");

    cur_req = "R5";
    repeat (5) @(negedge clk);
    pulse(16'd150);    chk(1'b1, "R5 hold");

    cur_req = "R4";
    pulse_n(16'd5, 4); do_clr(); chk(1'b0, "R4 cleared");
    pulse(16'd5);      chk(1'b1, "R4 saturated run resets irq");

    cur_req = "R7";
    pulse(16'd5);
    res = 16'd5; vld = 1'b1; clr = 1'b1;
    @(negedge clk);
    vld = 1'b0; clr = 1'b0;
    chk(1'b1, "R7 set beats clear");
    do_clr();

    cur_req = "R8";
    pulse(16'd150);
    set_pers(2'b11);
    pulse_n(16'd5, 3);
    set_pers(2'b01);
    pulse_n(16'd5, 3); chk(1'b0, "R8 run restarted");
    pulse(16'd5);      chk(1'b1, "R8 new run completes");
    do_clr();

    cur_req = "R9";
    pulse(16'd150);
    pulse_n(16'd5, 2);
    res = 16'd150; repeat (3) @(negedge clk);
    res = 16'd5;   repeat (3) @(negedge clk);
    chk(1'b0, "R9 idle not counted");
    pulse_n(16'd5, 2); chk(1'b1, "R9 run continued");
    do_clr();
    set_pers(2'b00);
    res = 16'd50; repeat (2) @(negedge clk);
    chk(1'b0, "R9 no strobe no set");

    cur_req = "R11";
    lo = 16'h0000; hi = 16'hFFFF;
    pulse(16'h0001); pulse(16'hFFFE); chk(1'b0, "R11 inner codes");
    pulse(16'h0000); chk(1'b1, "R11 zero");
    do_clr();
    pulse(16'hFFFF); chk(1'b1, "R11 full scale");
    do_clr();
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule